// File: doc/BRIEF.md
# DTMF Tone Pair Generator with Burst Timer

This block turns a 4-bit key code into a pair of digital sine sample streams, one for the low (row) group and one for the high (column) group. Each tone is produced by a segment counter that divides the master clock by a per-tone value and then steps a 5-bit phase through a 32-point sine. Because each period always has exactly 32 segments, the divide value alone sets the frequency. The row and column samples are given out on their own ports and also as a combined word. That word holds either their sum or just one of them, as the mode inputs select.

Two timing modes are available. In continuous mode the tone plays for as long as the enable input is held high. In burst mode a code write starts a fixed-length tone followed by an equally long silence, and a one-cycle ready pulse marks the end of the silence. The fixed length is about 51 ms of master clock, and it doubles when the extended-timing input is set. The analog conversion and filtering that follow the block are outside it.

Top module: `dtmf_burst_gen`

## Requirements
- R1: Key codes map to row/column divide values. Row 0 (divide DIV_R0) serves codes 1,2,3,13. Row 1 (DIV_R1) serves codes 4,5,6,14. Row 2 (DIV_R2) serves codes 7,8,9,15. Row 3 (DIV_R3) serves codes 0,10,11,12. Column 0 (DIV_C0) serves codes 1,4,7,11. Column 1 (DIV_C1) serves codes 2,5,8,10. Column 2 (DIV_C2) serves codes 3,6,9,12. Column 3 (DIV_C3) serves codes 0,13,14,15.
- R2: Once the tone starts, each phase advances by one after every `div` clock edges. A full period is 32 segments, and the phase wraps to 0 after segment 31.
- R3: A sample at phase p is round(A*sin(2*pi*p/32)) within ±1 LSB. For the column group A = 2^(SAMPLE_W-1)-1. For the row group A is that value times 794/1000, truncated.
- R4: In dual mode (`single_tone`=0), `mix_sample` is the sign-extended sum of row and column samples, one bit wider than either.
- R5: In single mode (`single_tone`=1), `mix_sample` carries only the column sample when `col_sel`=1, or only the row sample when `col_sel`=0.
- R6: While `tone_en` is low, both samples and `mix_sample` are 0. `tone_active`, `sample_valid` and `tx_ready` stay low, and a running burst is abandoned without a ready pulse.
- R7: In continuous mode (`burst_en`=0), `tone_active` follows `tone_en`, and a code write takes effect at once.
- R8: In burst mode, a code write while idle gives exactly L cycles of `tone_active` and then L silent cycles, with L = BURST_CYC. A single-cycle `tx_ready` pulse follows, in the cycle after the last silent cycle.
- R9: If `cp_mode` is high at the write that starts a burst, L = 2*BURST_CYC for both the tone and the silence.
- R10: In burst mode, a code write during the tone or the silence has no effect on either the frequencies or the timing.
- R11: `sample_valid` is high for one cycle in each cycle where either the row phase or the column phase has just advanced.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_wr | input | 1 | Write strobe for `code_in` |
| code_in | input | 4 | Key code |
| tone_en | input | 1 | Transmitter enable; low silences and idles everything |
| burst_en | input | 1 | 1 = timed burst/pause mode, 0 = continuous |
| cp_mode | input | 1 | Doubles burst and pause length |
| single_tone | input | 1 | 1 = one group on `mix_sample` |
| col_sel | input | 1 | In single mode: 1 = column, 0 = row |
| row_sample | output | SAMPLE_W | Signed low-group sample |
| col_sample | output | SAMPLE_W | Signed high-group sample |
| mix_sample | output | SAMPLE_W+1 | Signed combined sample |
| sample_valid | output | 1 | A phase advanced this cycle |
| tone_active | output | 1 | Tone is being produced |
| tx_ready | output | 1 | One-cycle pulse at end of burst pause |

## Verification
The bench checks the phase at exact edge counts, such as 2, 8, 24 and 32 segments in. A divider that is off by one, or one that counts its reload cycle twice, shows up there as a shifted or wrong-signed sample. It checks every cycle of the burst and pause windows, so a timer that is one cycle long or short, or that drops the ready pulse or repeats it, is caught. A code written in the middle of a burst must not retune the tone, and a design that loads it anyway gives a visibly different sample. Dropping the enable in the middle of a burst must leave no late ready pulse.

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen #(
  parameter int SAMPLE_W  = 12,
  parameter int BURST_CYC = 182557,
  parameter int DIV_R0 = 160,
  parameter int DIV_R1 = 146,
  parameter int DIV_R2 = 132,
  parameter int DIV_R3 = 118,
  parameter int DIV_C0 = 92,
  parameter int DIV_C1 = 84,
  parameter int DIV_C2 = 76,
  parameter int DIV_C3 = 68
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       code_wr,
  input  logic [3:0]                 code_in,
  input  logic                       tone_en,
  input  logic                       burst_en,
  input  logic                       cp_mode,
  input  logic                       single_tone,
  input  logic                       col_sel,
  output logic signed [SAMPLE_W-1:0] row_sample,
  output logic signed [SAMPLE_W-1:0] col_sample,
  output logic signed [SAMPLE_W:0]   mix_sample,
  output logic                       sample_valid,
  output logic                       tone_active,
  output logic                       tx_ready
);
  localparam int DIV_W  = $clog2(DIV_R0 + 1);
  localparam int BT_W   = $clog2(2 * BURST_CYC + 1);
  localparam int HI_AMP = (1 << (SAMPLE_W - 1)) - 1;
  localparam int LO_AMP = HI_AMP * 794 / 1000;

  typedef enum logic [1:0] {S_IDLE, S_TONE, S_GAP} bst_t;

  logic [3:0]       code_q;
  bst_t             bst;
  logic [BT_W-1:0]  bcnt, blen;
  logic             ready_q, step_q;
  logic [DIV_W-1:0] rcnt, ccnt, rdiv, cdiv;
  logic [4:0]       rph, cph;
  logic             run, busy, rwrap, cwrap;

  assign busy  = (bst != S_IDLE);
  assign run   = tone_en & (burst_en ? (bst == S_TONE) : 1'b1);
  assign rwrap = run && (rcnt >= rdiv - 1'b1);
  assign cwrap = run && (ccnt >= cdiv - 1'b1);

  always_comb begin
    case (code_q)
      4'd1, 4'd2, 4'd3, 4'd13:  rdiv = DIV_W'(DIV_R0);
      4'd4, 4'd5, 4'd6, 4'd14:  rdiv = DIV_W'(DIV_R1);
      4'd7, 4'd8, 4'd9, 4'd15:  rdiv = DIV_W'(DIV_R2);
      default:                  rdiv = DIV_W'(DIV_R3);
    endcase
    case (code_q)
      4'd1, 4'd4, 4'd7, 4'd11:  cdiv = DIV_W'(DIV_C0);
      4'd2, 4'd5, 4'd8, 4'd10:  cdiv = DIV_W'(DIV_C1);
      4'd3, 4'd6, 4'd9, 4'd12:  cdiv = DIV_W'(DIV_C2);
      default:                  cdiv = DIV_W'(DIV_C3);
    endcase
  end

  function automatic logic signed [SAMPLE_W-1:0] sine_pt(input logic [4:0] ph, input int amp);
    logic [3:0] k;
    int q16, mag;
    k = ph[3] ? (4'd8 - {1'b0, ph[2:0]}) : {1'b0, ph[2:0]};
    case (k)
      4'd0:    q16 = 0;
      4'd1:    q16 = 12785;
      4'd2:    q16 = 25080;
      4'd3:    q16 = 36410;
      4'd4:    q16 = 46341;
      4'd5:    q16 = 54491;
      4'd6:    q16 = 60547;
      4'd7:    q16 = 64277;
      default: q16 = 65536;
    endcase
    mag = (amp * q16 + 32768) >>> 16;
    return ph[4] ? SAMPLE_W'(-mag) : SAMPLE_W'(mag);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) code_q <= '0;
    else if (code_wr && !(burst_en && busy)) code_q <= code_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst <= S_IDLE; bcnt <= '0; blen <= '0; ready_q <= 1'b0;
    end else if (!tone_en || !burst_en) begin
      bst <= S_IDLE; bcnt <= '0; ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (bst)
        S_IDLE: if (code_wr) begin
          bst  <= S_TONE;
          bcnt <= '0;
          blen <= cp_mode ? BT_W'(2 * BURST_CYC) : BT_W'(BURST_CYC);
        end
        S_TONE: if (bcnt == blen - 1'b1) begin
          bst <= S_GAP; bcnt <= '0;
        end else bcnt <= bcnt + 1'b1;
        default: if (bcnt == blen - 1'b1) begin
          bst <= S_IDLE; bcnt <= '0; ready_q <= 1'b1;
        end else bcnt <= bcnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0; ccnt <= '0; rph <= '0; cph <= '0; step_q <= 1'b0;
    end else if (!run) begin
      rcnt <= '0; ccnt <= '0; rph <= '0; cph <= '0; step_q <= 1'b0;
    end else begin
      rcnt   <= rwrap ? '0 : rcnt + 1'b1;
      ccnt   <= cwrap ? '0 : ccnt + 1'b1;
      rph    <= rph + {4'd0, rwrap};
      cph    <= cph + {4'd0, cwrap};
      step_q <= rwrap | cwrap;
    end
  end

  assign row_sample   = run ? sine_pt(rph, LO_AMP) : '0;
  assign col_sample   = run ? sine_pt(cph, HI_AMP) : '0;
  assign mix_sample   = single_tone ? (col_sel ? (SAMPLE_W+1)'(col_sample) : (SAMPLE_W+1)'(row_sample))
                                    : (SAMPLE_W+1)'(row_sample) + (SAMPLE_W+1)'(col_sample);
  assign sample_valid = step_q;
  assign tone_active  = run;
  assign tx_ready     = ready_q;

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
  p_ready_after_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(bst == S_GAP));
  p_bcnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < blen);
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rph != $past(rph)) |-> (rph == $past(rph) + 5'd1 || rph == 5'd0));
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> (rph == 5'd0 && cph == 5'd0 && bst == S_IDLE));
  p_hold_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && busy && code_wr) |=> $stable(code_q));
endmodule

// File: tb/dtmf_burst_gen_bench.sv
module dtmf_burst_gen_bench;
  localparam int W   = 12;
  localparam int LEN = 300;
  localparam int HA  = (1 << (W - 1)) - 1;
  localparam int LA  = HA * 794 / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic code_wr = 1'b0, tone_en = 1'b0, burst_en = 1'b0, cp_mode = 1'b0;
  logic single_tone = 1'b0, col_sel = 1'b0;
  logic [3:0] code_in = 4'd0;
  logic signed [W-1:0] row_sample, col_sample;
  logic signed [W:0]   mix_sample;
  logic sample_valid, tone_active, tx_ready;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtmf_burst_gen #(.SAMPLE_W(W), .BURST_CYC(LEN)) u_dtmf_burst_gen (
    .clk(clk), .rst_n(rst_n), .code_wr(code_wr), .code_in(code_in),
    .tone_en(tone_en), .burst_en(burst_en), .cp_mode(cp_mode),
    .single_tone(single_tone), .col_sel(col_sel),
    .row_sample(row_sample), .col_sample(col_sample), .mix_sample(mix_sample),
    .sample_valid(sample_valid), .tone_active(tone_active), .tx_ready(tx_ready));

  function automatic int exp_s(int ph, int amp);
    real v;
    v = amp * $sin(2.0 * 3.14159265358979 * (ph % 32) / 32.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int row_div(int c);
    case (c)
      1, 2, 3, 13: return 160;
      4, 5, 6, 14: return 146;
      7, 8, 9, 15: return 132;
      default:     return 118;
    endcase
  endfunction

  function automatic int col_div(int c);
    case (c)
      1, 4, 7, 11: return 92;
      2, 5, 8, 10: return 84;
      3, 6, 9, 12: return 76;
      default:     return 68;
    endcase
  endfunction

  task automatic chk(string req, int act, int expv, int tol);
    total++;
    if (act - expv > tol || expv - act > tol) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cont(int c);
    tone_en = 1'b0; burst_en = 1'b0;
    @(negedge clk);
    code_in = 4'(c); code_wr = 1'b1;
    @(negedge clk);
    code_wr = 1'b0; tone_en = 1'b1;
  endtask

  task automatic t_reset;
    chk("R12 row", row_sample, 0, 0);
    chk("R12 col", col_sample, 0, 0);
    chk("R12 mix", mix_sample, 0, 0);
    chk("R12 flags", {sample_valid, tone_active, tx_ready}, 0, 0);
  endtask

  task automatic t_single_row;
    int t;
    int marks[4] = '{320, 1280, 3840, 5120};
    single_tone = 1'b1; col_sel = 1'b0;
    load_cont(1);
    t = 0;
    foreach (marks[i]) begin
      wait_cyc(marks[i] - t);
      t = marks[i];
      chk("R2/R3 row phase", row_sample, exp_s(t / 160, LA), 1);
      chk("R3 col phase", col_sample, exp_s(t / 92, HA), 1);
      chk("R5 single row mix", mix_sample, row_sample, 0);
    end
    chk("R7 active", tone_active, 1, 0);
    col_sel = 1'b1;
    @(negedge clk);
    chk("R5 single col mix", mix_sample, col_sample, 0);
    single_tone = 1'b0;
  endtask

  task automatic t_digits;
    int codes[5] = '{0, 10, 12, 14, 8};
    foreach (codes[i]) begin
      load_cont(codes[i]);
      wait_cyc(700);
      chk("R1 row", row_sample, exp_s(700 / row_div(codes[i]), LA), 1);
      chk("R1 col", col_sample, exp_s(700 / col_div(codes[i]), HA), 1);
      chk("R4 mix sum", mix_sample, int'(row_sample) + int'(col_sample), 0);
    end
  endtask

  task automatic t_silent;
    int errs = 0;
    tone_en = 1'b0; burst_en = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (row_sample != 0 || col_sample != 0 || mix_sample != 0 || tone_active || sample_valid || tx_ready) errs++;
    end
    chk("R6 silent cycles", errs, 0, 0);
  endtask

  task automatic t_valid;
    int errs = 0;
    load_cont(6);
    for (int e = 1; e <= 2000; e++) begin
      @(posedge clk); @(negedge clk);
      if (sample_valid != ((e % 146 == 0) || (e % 76 == 0))) errs++;
    end
    chk("R11 valid per cycle", errs, 0, 0);
    tone_en = 1'b0;
  endtask

  task automatic run_burst(int c, bit cp, int len, int late_wr_at, int late_code,
                           int probe_at, int probe_exp, string tag);
    int act = 0, rdy = 0, rdy_at = 0, gap_err = 0;
    tone_en = 1'b1; burst_en = 1'b1; cp_mode = cp;
    @(negedge clk);
    code_in = 4'(c); code_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    code_wr = 1'b0;
    if (tone_active) act++;
    for (int i = 2; i <= 3 * len; i++) begin
      if (i == late_wr_at) begin code_in = 4'(late_code); code_wr = 1'b1; end
      else code_wr = 1'b0;
      @(posedge clk); @(negedge clk);
      if (tone_active) act++;
      if (tx_ready) begin rdy++; rdy_at = i; end
      if (i > len + 1 && i <= 2 * len + 1 && (row_sample != 0 || col_sample != 0)) gap_err++;
      if (i == probe_at) chk({tag, " probe row"}, row_sample, probe_exp, 1);
    end
    chk({tag, " tone cycles"}, act, len, 0);
    chk({tag, " ready count"}, rdy, 1, 0);
    chk({tag, " ready cycle"}, rdy_at, 2 * len + 1, 0);
    chk({tag, " pause silent"}, gap_err, 0, 0);
  endtask

  task automatic t_abort;
    int rdy = 0;
    tone_en = 1'b1; burst_en = 1'b1; cp_mode = 1'b0;
    @(negedge clk);
    code_in = 4'd5; code_wr = 1'b1;
    @(negedge clk);
    code_wr = 1'b0;
    wait_cyc(100);
    tone_en = 1'b0;
    @(negedge clk);
    chk("R6 abort inactive", tone_active, 0, 0);
    tone_en = 1'b1;
    for (int i = 0; i < 3 * LEN; i++) begin
      @(negedge clk);
      if (tx_ready) rdy++;
    end
    chk("R6 abort no ready", rdy, 0, 0);
    tone_en = 1'b0; burst_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_row();
    t_digits();
    t_silent();
    t_valid();
    run_burst(1, 1'b0, LEN, 0, 0, 250, exp_s(249 / 160, LA), "R8");
    run_burst(1, 1'b1, 2 * LEN, 0, 0, 500, exp_s(499 / 160, LA), "R9");
    run_burst(1, 1'b0, LEN, 50, 0, 290, exp_s(289 / 160, LA), "R10");
    t_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule